// File: doc/BRIEF.md
# Register Mailbox Flash Command Engine

The block is a device-side command mailbox that a host drives purely through 32-bit register accesses at dword offsets. The host stages up to sixteen dwords in a bank of data registers and then writes a command word whose lowest bit requests an operation. While the operation runs, that bit reads back as 1. The engine clears it when the work is done and leaves a result word in a status register. The host therefore polls the command register and then reads the status register.

Four operations exist. A block write copies staged dwords into the non-active flash area, or into a fixed header region when the header flag is set. A block read fetches dwords into the data registers. An authentication check compares the first header dword against a key. A power cycle wipes the data and status registers. The flash is modelled as an internal dword array of `2*AREA_DW + HDR_DW` words. The active area is at array addresses `0..AREA_DW-1`, the non-active area starts at `AREA_DW`, and the header region starts at `2*AREA_DW`. Each command occupies the engine for a fixed `CYC_PER_DW` cycles per dword moved, so the busy window can be seen from the host side.

Top module: `mbox_flash_engine`

## Requirements
- R1: Offsets 1..16 are data registers that read back what the host last wrote to them. Offset 17 reads the command register and offset 18 reads the status register. Writes to offset 18 have no effect, and every other offset reads 0.
- R2: A command write whose bit 0 is 1, accepted while the engine is idle, makes offset 17 read that word with bit 0 equal to 1 from the next clock edge onward. When the command finishes, offset 17 reads the same word with bit 0 cleared.
- R3: The request bit stays at 1 for exactly N*CYC_PER_DW cycles. N is the dword count of an in-range read or write command, and N is 1 for every other command.
- R4: While a command runs, host writes to offsets 1..17 are ignored. A command write with bit 0 equal to 0 is ignored at all times.
- R5: On completion, the status register reads {bit 29 = 1, bits 7:4 = command code, bits 3:0 = result}, with all other bits 0. The result is 0 for success, 1 for an authentication failure and 2 for an access error.
- R6: The command word holds the code in bits 31:28, the count in bits 27:24, the dword address in bits 23:2, the header flag in bit 1 and the request in bit 0. For a read (code 2), a count of 0 moves 16 dwords and any other count moves exactly that many dwords. The dwords come from array addresses addr, addr+1 and so on, and land in offsets 1, 2 and so on. Data registers above the count keep their values.
- R7: A write (code 0) with the header flag clear moves count+1 dwords from offsets 1 and upward. They go to array address AREA_DW+addr and upward, where a read command at that address returns them.
- R8: A write with the header flag set stores its dwords starting at array address 2*AREA_DW, whatever the address field holds.
- R9: Some commands finish with result 2 and leave the array and data registers untouched. These are a read whose end would exceed the array, a non-header write whose end exceeds AREA_DW, a header write of more than HDR_DW dwords, and any code other than 0, 1, 2 or 4.
- R10: Authentication (code 1) finishes with result 0 when array word 2*AREA_DW equals AUTH_KEY, and with result 1 otherwise.
- R11: When a power cycle (code 4) finishes, all data registers and the status register read 0.
- R12: After reset, the data, command and status registers read 0. Array word i holds INIT_SEED ^ (i * 32'h9E3779B1), truncated to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe; qualifies writes |
| reg_write | input | 1 | 1 = write access, 0 = read |
| reg_offset | input | OFFW | Dword offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_offset |

## Verification
The engine and the host both own the data registers, and each can touch them in the same cycle. The first collision comes from a host data write, or a second command write, made the cycle right after a command has been accepted and while the engine is still moving dwords. The bench issues a long block write and hits the data bank and the command register at once. It then judges the outcome through a read-back of the flash area, which must hold the staged values and not the intruding ones, and through an unchanged command word. A second collision falls on the completion edge, where the status and the request bit change together. A per-cycle reference model compares every read value, so an off-by-one in the busy window or the status update shows as a mismatch.

// File: rtl/mbox_pkg.sv
// Shared constants for the register mailbox flash engine.
// Assumes the fixed 32-bit command/status word layout described in the brief.
package mbox_pkg;

    typedef enum logic [3:0] {
        OP_WRITE = 4'd0,
        OP_AUTH  = 4'd1,
        OP_READ  = 4'd2,
        OP_PWR   = 4'd4
    } mbox_op_e;

    localparam logic [3:0] RES_OK   = 4'd0;
    localparam logic [3:0] RES_AUTH = 4'd1;
    localparam logic [3:0] RES_ACC  = 4'd2;

    // Build a completion word: response flag, echoed code, result.
    function automatic logic [31:0] make_status(input logic [3:0] code, input logic [3:0] res);
        return {2'b00, 1'b1, 21'd0, code, res};
    endfunction

endpackage

// File: rtl/mbox_flash.sv
// Flash model: dword array with a synchronous write port and a read port that
// the consumer samples on its own clock edge. Reset loads a computed pattern.
// Assumes waddr/raddr are below DEPTH whenever they are used.
module mbox_flash #(
    parameter int          DEPTH = 144,
    parameter logic [31:0] SEED  = 32'h5A5A_0000,
    localparam int         AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);

    logic [31:0] mem [DEPTH];

    // Array storage: pattern on reset, single-dword write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= SEED ^ (32'(i) * 32'h9E37_79B1);
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    AST_WRITE_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (32'(addr) < DEPTH)); // R9

endmodule

// File: rtl/mbox_regs.sv
// Bank of mailbox data dwords shared by the host and the engine.
// Engine loads take priority; the top gates host writes while busy, so the
// two never collide. A clear wipes the whole bank in one cycle.
module mbox_regs #(
    parameter int  DW   = 16,
    localparam int IDXW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            host_we,
    input  logic [IDXW-1:0] host_idx,
    input  logic [31:0]     host_wdata,
    output logic [31:0]     host_rdata,
    input  logic            eng_we,
    input  logic [IDXW-1:0] eng_idx,
    input  logic [31:0]     eng_wdata,
    output logic [31:0]     eng_rdata
);

    logic [DW-1:0][31:0] words;

    for (genvar g = 0; g < DW; g++) begin : g_word
        logic [31:0] q;
        // One data dword: reset/clear, engine load, then host write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                q <= '0;
            end else if (eng_we && (eng_idx == IDXW'(g))) begin
                q <= eng_wdata;
            end else if (host_we && (host_idx == IDXW'(g))) begin
                q <= host_wdata;
            end
        end
        assign words[g] = q;
    end

    assign host_rdata = words[host_idx];
    assign eng_rdata  = words[eng_idx];

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && eng_we)); // R4

endmodule

// File: rtl/mbox_ctrl.sv
// Command sequencer: decodes and accepts command words, range-checks them,
// paces dword moves at CPD cycles each, and posts the status word.
// Assumes DW == 16 so the 4-bit count field covers the full bank.
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          AREA_DW  = 64,
    parameter int          HDR_DW   = 16,
    parameter int          CPD      = 4,
    parameter logic [31:0] AUTH_KEY = 32'hC0DE_5EA1,
    localparam int         DEPTH    = 2 * AREA_DW + HDR_DW,
    localparam int         AW       = $clog2(DEPTH),
    localparam int         IDXW     = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [31:0]     cmd_wdata,
    input  logic [31:0]     flash_rdata,
    input  logic [31:0]     regs_rdata,
    output logic            busy,
    output logic [31:0]     cmd_word,
    output logic [31:0]     stat_word,
    output logic            flash_we,
    output logic [AW-1:0]   flash_addr,
    output logic [31:0]     flash_wdata,
    output logic            regs_we,
    output logic [IDXW-1:0] regs_idx,
    output logic [31:0]     regs_wdata,
    output logic            regs_clr
);

    localparam int            NW       = IDXW + 1;
    localparam int            CW       = (CPD > 1) ? $clog2(CPD) : 1;
    localparam logic [AW-1:0] HDR_BASE = AW'(2 * AREA_DW);
    localparam logic [22:0]   LIM_ALL  = 23'(DEPTH);
    localparam logic [22:0]   LIM_AREA = 23'(AREA_DW);

    logic            busy_q;
    logic [31:1]     cmd_q;
    logic [31:0]     stat_q;
    logic [NW-1:0]   n_q;
    logic [IDXW-1:0] idx_q;
    logic [CW-1:0]   cyc_q;
    logic [AW-1:0]   base_q;
    logic            xfer_q, rd_q, err_q;

    logic [3:0]      d_code, d_cnt;
    logic [21:0]     d_addr;
    logic            d_hdr;
    logic [NW-1:0]   d_n;
    logic [22:0]     d_end;
    logic [AW-1:0]   d_base;
    logic            d_ok, d_xfer, d_rd;
    logic            start, tick, last;
    logic [3:0]      res;

    assign d_code = cmd_wdata[31:28];
    assign d_cnt  = cmd_wdata[27:24];
    assign d_addr = cmd_wdata[23:2];
    assign d_hdr  = cmd_wdata[1];

    // Decode a candidate command: dword count, base address, legality.
    always_comb begin
        d_n    = NW'(1);
        d_end  = '0;
        d_base = '0;
        d_ok   = 1'b1;
        d_xfer = 1'b0;
        d_rd   = 1'b0;
        case (d_code)
            OP_READ: begin
                d_n    = (d_cnt == 4'd0) ? NW'(DW) : NW'(d_cnt);
                d_end  = {1'b0, d_addr} + 23'(d_n);
                d_ok   = (d_end <= LIM_ALL);
                d_rd   = 1'b1;
                d_xfer = 1'b1;
                d_base = AW'(d_addr);
            end
            OP_WRITE: begin
                d_n    = NW'(d_cnt) + NW'(1);
                d_xfer = 1'b1;
                if (d_hdr) begin
                    d_ok   = (32'(d_n) <= HDR_DW);
                    d_base = HDR_BASE;
                end else begin
                    d_end  = {1'b0, d_addr} + 23'(d_n);
                    d_ok   = (d_end <= LIM_AREA);
                    d_base = AW'(AREA_DW) + AW'(d_addr);
                end
            end
            OP_AUTH: d_base = HDR_BASE;
            OP_PWR:  d_base = '0;
            default: d_ok = 1'b0;
        endcase
        if (!d_ok) begin
            d_n    = NW'(1);
            d_xfer = 1'b0;
        end
    end

    assign start = cmd_we && !busy_q && cmd_wdata[0];
    assign tick  = busy_q && (cyc_q == CW'(CPD - 1));
    assign last  = tick && (NW'(idx_q) == (n_q - NW'(1)));

    // Result selection at completion.
    always_comb begin
        if (err_q) begin
            res = RES_ACC;
        end else if (cmd_q[31:28] == OP_AUTH) begin
            res = (flash_rdata == AUTH_KEY) ? RES_OK : RES_AUTH;
        end else begin
            res = RES_OK;
        end
    end

    // Sequencer state: accept, pace, finish and post status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cmd_q  <= '0;
            stat_q <= '0;
            n_q    <= '0;
            idx_q  <= '0;
            cyc_q  <= '0;
            base_q <= '0;
            xfer_q <= 1'b0;
            rd_q   <= 1'b0;
            err_q  <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cmd_q  <= cmd_wdata[31:1];
            n_q    <= d_n;
            idx_q  <= '0;
            cyc_q  <= '0;
            base_q <= d_base;
            xfer_q <= d_xfer;
            rd_q   <= d_rd;
            err_q  <= !d_ok;
        end else if (busy_q) begin
            if (tick) begin
                cyc_q <= '0;
                if (last) begin
                    busy_q <= 1'b0;
                    stat_q <= (cmd_q[31:28] == OP_PWR) ? 32'd0 : make_status(cmd_q[31:28], res);
                end else begin
                    idx_q <= idx_q + IDXW'(1);
                end
            end else begin
                cyc_q <= cyc_q + CW'(1);
            end
        end
    end

    assign busy        = busy_q;
    assign cmd_word    = {cmd_q, busy_q};
    assign stat_word   = stat_q;
    assign flash_addr  = base_q + AW'(idx_q);
    assign flash_we    = tick && xfer_q && !rd_q;
    assign flash_wdata = regs_rdata;
    assign regs_idx    = idx_q;
    assign regs_we     = tick && xfer_q && rd_q;
    assign regs_wdata  = flash_rdata;
    assign regs_clr    = last && (cmd_q[31:28] == OP_PWR) && !err_q;

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tick) |=> busy_q); // R3
    AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cmd_we) |=> $stable(cmd_q)); // R4
    AST_STATUS_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (stat_q[29] || (stat_q == 32'd0))); // R5
    AST_CODE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && stat_q[29]) |-> (stat_q[7:4] == cmd_q[31:28])); // R5
    AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[3:0] <= RES_ACC); // R5
    AST_MOVE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && xfer_q) |-> (32'(flash_addr) < DEPTH)); // R9

endmodule

// File: rtl/mbox_flash_engine.sv
// Top of the register mailbox flash engine: decodes host register accesses,
// blocks host writes while a command runs, and muxes read data.
// Assumes single-cycle register accesses; read data is combinational.
module mbox_flash_engine #(
    parameter int          MBOX_DW    = 16,
    parameter int          AREA_DW    = 64,
    parameter int          HDR_DW     = 16,
    parameter int          CYC_PER_DW = 4,
    parameter logic [31:0] AUTH_KEY   = 32'hC0DE_5EA1,
    parameter logic [31:0] INIT_SEED  = 32'h5A5A_0000,
    localparam int         OFFW       = $clog2(MBOX_DW + 3)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_valid,
    input  logic            reg_write,
    input  logic [OFFW-1:0] reg_offset,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata
);

    localparam int            DEPTH    = 2 * AREA_DW + HDR_DW;
    localparam int            AW       = $clog2(DEPTH);
    localparam int            IDXW     = $clog2(MBOX_DW);
    localparam logic [OFFW-1:0] OFF_CMD  = OFFW'(MBOX_DW + 1);
    localparam logic [OFFW-1:0] OFF_STAT = OFFW'(MBOX_DW + 2);

    logic            is_data, busy, host_we, cmd_we;
    logic [IDXW-1:0] host_idx, e_idx;
    logic [31:0]     host_rdata, e_rdata, e_wdata, cmd_word, stat_word;
    logic [31:0]     f_rdata, f_wdata;
    logic [AW-1:0]   f_addr;
    logic            f_we, e_we, e_clr;

    assign is_data  = (reg_offset >= OFFW'(1)) && (reg_offset <= OFFW'(MBOX_DW));
    assign host_idx = IDXW'(reg_offset - OFFW'(1));
    assign host_we  = reg_valid && reg_write && is_data && !busy;
    assign cmd_we   = reg_valid && reg_write && (reg_offset == OFF_CMD);

    // Read-data selection by offset.
    always_comb begin
        if (is_data) begin
            reg_rdata = host_rdata;
        end else if (reg_offset == OFF_CMD) begin
            reg_rdata = cmd_word;
        end else if (reg_offset == OFF_STAT) begin
            reg_rdata = stat_word;
        end else begin
            reg_rdata = '0;
        end
    end

    mbox_regs #(.DW(MBOX_DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (e_clr),
        .host_we    (host_we),
        .host_idx   (host_idx),
        .host_wdata (reg_wdata),
        .host_rdata (host_rdata),
        .eng_we     (e_we),
        .eng_idx    (e_idx),
        .eng_wdata  (e_wdata),
        .eng_rdata  (e_rdata)
    );

    mbox_ctrl #(
        .DW       (MBOX_DW),
        .AREA_DW  (AREA_DW),
        .HDR_DW   (HDR_DW),
        .CPD      (CYC_PER_DW),
        .AUTH_KEY (AUTH_KEY)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_wdata   (reg_wdata),
        .flash_rdata (f_rdata),
        .regs_rdata  (e_rdata),
        .busy        (busy),
        .cmd_word    (cmd_word),
        .stat_word   (stat_word),
        .flash_we    (f_we),
        .flash_addr  (f_addr),
        .flash_wdata (f_wdata),
        .regs_we     (e_we),
        .regs_idx    (e_idx),
        .regs_wdata  (e_wdata),
        .regs_clr    (e_clr)
    );

    mbox_flash #(.DEPTH(DEPTH), .SEED(INIT_SEED)) u_flash (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (f_we),
        .addr  (f_addr),
        .wdata (f_wdata),
        .rdata (f_rdata)
    );

    AST_REQ_BIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_word[0]) |-> (cmd_word[31:1] == $past(cmd_word[31:1]))); // R2
    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_valid && reg_write && is_data && !e_we && !e_clr) |=>
        (host_idx != $past(host_idx)) || (host_rdata == $past(host_rdata))); // R4

endmodule

// File: tb/mbox_flash_engine_tb.sv
`timescale 1ns/1ps
module mbox_flash_engine_tb;

    localparam int          DW    = 16;
    localparam int          AREA  = 64;
    localparam int          HDR   = 16;
    localparam int          DEPTH = 2 * AREA + HDR;
    localparam int          HB    = 2 * AREA;
    localparam int          CPD   = 4;
    localparam logic [31:0] KEY   = 32'hC0DE_5EA1;
    localparam logic [31:0] SEED  = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [4:0]  reg_offset = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;

    mbox_flash_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_offset(reg_offset), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] pat(input int i);
        return SEED ^ (32'(i) * 32'h9E37_79B1);
    endfunction

    function automatic logic [31:0] mk(input int code, input int cnt, input int addr, input bit hdr);
        return {4'(code), 4'(cnt), 22'(addr), hdr, 1'b1};
    endfunction

    function automatic logic [31:0] st(input int code, input int res);
        return 32'h2000_0000 | (32'(code) << 4) | 32'(res);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_data [DW];
    logic [31:0] m_mem [DEPTH];
    logic [31:0] m_cmd, m_stat;
    int m_busy, m_cyc, m_idx, m_n, m_base, m_xfer, m_isrd, m_err, m_code;

    task automatic m_start(input logic [31:0] w);
        int code, cnt, addr, ok;
        code = int'(w[31:28]); cnt = int'(w[27:24]); addr = int'(w[23:2]);
        ok = 1; m_xfer = 0; m_isrd = 0; m_n = 1; m_base = 0;
        if (code == 2) begin
            m_n = (cnt == 0) ? 16 : cnt; m_isrd = 1; m_base = addr;
            ok = (addr + m_n <= DEPTH);
            m_xfer = 1;
        end else if (code == 0) begin
            m_n = cnt + 1; m_xfer = 1;
            if (w[1]) begin ok = (m_n <= HDR); m_base = HB; end
            else begin ok = (addr + m_n <= AREA); m_base = AREA + addr; end
        end else if (code != 1 && code != 4) begin
            ok = 0;
        end
        if (!ok) begin m_n = 1; m_xfer = 0; end
        m_err = !ok; m_code = code;
        m_cmd = w & 32'hFFFF_FFFE;
        m_busy = 1; m_cyc = 0; m_idx = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DW; i++) m_data[i] = '0;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = pat(i);
            m_cmd = '0; m_stat = '0; m_busy = 0; m_cyc = 0; m_idx = 0;
            cmp_en = 1;
        end else if (m_busy != 0) begin
            m_cyc++;
            if (m_cyc == CPD) begin
                m_cyc = 0;
                if (m_xfer != 0) begin
                    if (m_isrd != 0) m_data[m_idx] = m_mem[m_base + m_idx];
                    else m_mem[m_base + m_idx] = m_data[m_idx];
                end
                m_idx++;
                if (m_idx == m_n) begin
                    m_busy = 0;
                    if (m_err != 0) m_stat = st(m_code, 2);
                    else if (m_code == 1) m_stat = st(1, (m_mem[HB] == KEY) ? 0 : 1);
                    else if (m_code == 4) begin
                        m_stat = '0;
                        for (int i = 0; i < DW; i++) m_data[i] = '0;
                    end else m_stat = st(m_code, 0);
                end
            end
        end else if (reg_valid && reg_write) begin
            if (reg_offset >= 1 && reg_offset <= 16) m_data[reg_offset - 1] = reg_wdata;
            else if (reg_offset == 17 && reg_wdata[0]) m_start(reg_wdata);
        end
    end

    function automatic logic [31:0] m_read(input int off);
        if (off >= 1 && off <= 16) return m_data[off - 1];
        if (off == 17) return m_cmd | 32'(m_busy != 0);
        if (off == 18) return m_stat;
        return '0;
    endfunction

    // Per-cycle comparison against the model, away from the edge (R1..R12).
    always @(posedge clk) begin
        #1;
        if (cmp_en && rst_n) chk("R1 model-compare", reg_rdata, m_read(int'(reg_offset)));
    end

    // ---------------- host tasks ----------------
    task automatic wr(input int off, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_offset = 5'(off); reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic rd(input int off, output logic [31:0] v);
        @(negedge clk);
        reg_offset = 5'(off);
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 400; k++) begin
            rd(17, v);
            if (!v[0]) break;
        end
    endtask

    task automatic run(input logic [31:0] w);
        wr(17, w);
        wait_idle();
    endtask

    task automatic expect_reg(input string tag, input int off, input logic [31:0] exp);
        logic [31:0] v;
        rd(off, v);
        chk(tag, v, exp);
    endtask

    // Count cycles with the request bit set, sampling right after issue.
    task automatic busy_len(input logic [31:0] w, output int len);
        wr(17, w);
        reg_offset = 5'd17;
        len = 0;
        #1;
        while (reg_rdata[0] && len < 400) begin
            len++;
            @(negedge clk); #1;
        end
    endtask

    // Read one array word through a read command.
    task automatic peek(input string tag, input int addr, input logic [31:0] exp);
        run(mk(2, 1, addr, 0));
        expect_reg(tag, 1, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            n_fail++;
            $display("FAIL watchdog expired got=%0d exp=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R12 reset state
        expect_reg("R12 data1 reset", 1, 32'd0);
        expect_reg("R12 data16 reset", 16, 32'd0);
        expect_reg("R12 cmd reset", 17, 32'd0);
        expect_reg("R12 status reset", 18, 32'd0);
        peek("R12 array word 0", 0, pat(0));
        expect_reg("R5 read status", 18, st(2, 0));

        // R1 register map
        for (int k = 1; k <= 16; k++) wr(k, 32'h1000 + 32'(k));
        for (int k = 1; k <= 16; k++) expect_reg("R1 data readback", k, 32'h1000 + 32'(k));
        expect_reg("R1 offset 0 reads 0", 0, 32'd0);
        expect_reg("R1 offset 19 reads 0", 19, 32'd0);
        wr(18, 32'hFFFF_FFFF);
        expect_reg("R1 status read-only", 18, st(2, 0));

        // R6 read counts
        run(mk(2, 3, 5, 0));
        for (int k = 1; k <= 3; k++) expect_reg("R6 read 3 dwords", k, pat(4 + k));
        expect_reg("R6 dword above count kept", 4, 32'h1004);
        run(mk(2, 0, 10, 0));
        for (int k = 1; k <= 16; k++) expect_reg("R6 count 0 is 16", k, pat(9 + k));

        // R2 / R3 busy window
        busy_len(mk(0, 1, 30, 0), len);
        chk("R3 write 2 dwords busy", 32'(len), 32'(2 * CPD));
        expect_reg("R2 request bit cleared", 17, mk(0, 1, 30, 0) & 32'hFFFF_FFFE);
        busy_len(mk(1, 0, 0, 0), len);
        chk("R3 auth busy", 32'(len), 32'(CPD));
        expect_reg("R10 auth fails on pattern", 18, st(1, 1));

        // R7 block write and read-back
        for (int k = 1; k <= 4; k++) wr(k, 32'hA000_0000 + 32'(k));
        run(mk(0, 3, 7, 0));
        expect_reg("R7 write status", 18, st(0, 0));
        run(mk(2, 5, AREA + 7, 0));
        for (int k = 1; k <= 4; k++) expect_reg("R7 written data", k, 32'hA000_0000 + 32'(k));
        expect_reg("R7 neighbour untouched", 5, pat(AREA + 11));

        // R4 host access during busy
        for (int k = 1; k <= 4; k++) wr(k, 32'hB000_0000 + 32'(k));
        wr(17, mk(0, 3, 20, 0));
        wr(17, mk(2, 1, 0, 0));
        wr(2, 32'hDEAD_BEEF);
        wait_idle();
        expect_reg("R4 cmd kept", 17, mk(0, 3, 20, 0) & 32'hFFFF_FFFE);
        expect_reg("R4 status of first cmd", 18, st(0, 0));
        expect_reg("R4 data write ignored", 2, 32'hB000_0002);
        run(mk(2, 4, AREA + 20, 0));
        for (int k = 1; k <= 4; k++) expect_reg("R4 staged data written", k, 32'hB000_0000 + 32'(k));
        wr(17, mk(2, 1, 0, 0) & 32'hFFFF_FFFE);
        expect_reg("R4 no-request write ignored", 17, mk(2, 4, AREA + 20, 0) & 32'hFFFF_FFFE);
        expect_reg("R4 no-request data kept", 1, 32'hB000_0001);

        // R8 header write, R10 authentication
        wr(1, KEY);
        run(mk(0, 0, 3, 1));
        expect_reg("R8 header write status", 18, st(0, 0));
        peek("R8 header holds data", HB, KEY);
        peek("R8 given address untouched", AREA + 3, pat(AREA + 3));
        run(mk(1, 0, 0, 0));
        expect_reg("R10 auth passes", 18, st(1, 0));
        wr(1, 32'd0);
        run(mk(0, 0, 0, 1));
        run(mk(1, 0, 0, 0));
        expect_reg("R10 auth fails", 18, st(1, 1));

        // R9 range and code errors
        wr(1, 32'hC0C0_C0C0);
        run(mk(2, 4, DEPTH - 2, 0));
        expect_reg("R9 read past end status", 18, st(2, 2));
        expect_reg("R9 data untouched", 1, 32'hC0C0_C0C0);
        run(mk(0, 1, AREA - 1, 0));
        expect_reg("R9 write past area status", 18, st(0, 2));
        peek("R9 array untouched", AREA + AREA - 1, pat(2 * AREA - 1));
        run(mk(7, 0, 0, 0));
        expect_reg("R9 unknown code", 18, st(7, 2));
        run(mk(2, 2, DEPTH - 2, 0));
        expect_reg("R9 exact end accepted", 18, st(2, 0));
        expect_reg("R9 last word", 2, pat(DEPTH - 1));

        // R11 power cycle
        wr(1, 32'd5);
        run(mk(4, 0, 0, 0));
        for (int k = 1; k <= 16; k++) expect_reg("R11 data cleared", k, 32'd0);
        expect_reg("R11 status cleared", 18, 32'd0);
        expect_reg("R2 power cmd readback", 17, 32'h4000_0000);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule